// File: doc/BRIEF.md
# Reconfigurable Two-Stage Noise-Shaping Recombiner

This block is the digital back end of a cascade of two second-order sigma-delta modulator stages. On every sample strobe it takes one bit from each stage. When the cascade runs at fourth order, it merges the two bitstreams into a small signed word. The merge uses a recombination filter that delays the first-stage bit by two samples and shapes the second-stage bit with a double differentiator, so the first-stage quantization error cancels in the sum. When the cascade runs at second order, the first stage is powered down and the second-stage bit passes through to a single-bit output.

The block also holds the active operating mode and decodes it into settings for the analog side: loop order, sample-rate code, bandwidth, bias code and the three topology selectors. Those selectors are the first-stage enable, the input routing and the output tap. A new mode request is taken only on a sample strobe. The strobe that accepts it clears the filter history, and the next two samples are flagged invalid while the filter refills.

Top module: `mash_recomb`

## Requirements
- R1: Mode code 2'b00 (low power) gives order4=0, rate_code=0 (768 kHz), bw_wide=0 (4 kHz), bias_code=0 (50 %), and all three topology selectors low.
- R2: Mode code 2'b01 (standard) gives order4=1, rate_code=1 (2.4 MHz), bw_wide=1 (20 kHz), bias_code=1 (75 %). Mode 2'b10 (high resolution) gives order4=1, rate_code=2 (3.6 MHz), bw_wide=1, bias_code=2 (100 %). Mode 2'b11 decodes like 2'b01. In fourth-order modes all three selectors are high.
- R3: In fourth-order mode, with each bit read as +1 for 1 and -1 for 0, a processed sample n gives y_word = a[n-2] + b[n] - 2·b[n-1] + b[n-2]. Here a is the stage-1 bit and b is the stage-2 bit. y_word appears on the clock edge that samples the strobe, and y_bit is 0.
- R4: y_word is a two's-complement value of width OUT_W (4) that always lies in -5..+5.
- R5: In second-order mode, a processed sample sets y_bit to the stage-2 bit and y_word to 0. The stage-1 bit has no effect.
- R6: mode_sel is ignored on cycles without a strobe. The mode and the decoded settings change only on a strobe.
- R7: A strobe whose mode_sel differs from the active mode switches the mode and clears the filter history, with cleared taps counting as 0. That strobe produces y_valid=0, y_word=0 and y_bit=0. The next two processed samples have y_valid=0, and later ones have y_valid=1. Reset behaves like a switch to mode 2'b00.
- R8: y_valid is high only in the cycle after a strobe. y_word and y_bit hold their values between strobes.
- R9: After reset, the active mode is 2'b00, and y_valid, y_word and y_bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Requested operating mode |
| smp_tick | input | 1 | Sample strobe |
| s1_bit | input | 1 | First-stage output bit |
| s2_bit | input | 1 | Second-stage output bit |
| y_word | output | 4 | Merged signed output word (fourth order) |
| y_bit | output | 1 | Pass-through bit (second order) |
| y_valid | output | 1 | Output sample valid |
| order4 | output | 1 | 1 = fourth-order loop |
| rate_code | output | 2 | Sample-rate setting |
| bw_wide | output | 1 | 1 = 20 kHz bandwidth, 0 = 4 kHz |
| bias_code | output | 2 | Bias-current setting |
| s1_enable | output | 1 | First-stage power enable |
| s1_input_sel | output | 1 | 1 = input to first stage, 0 = to second stage |
| tap_merged | output | 1 | 1 = output taken from merged word |

## Verification
In fourth order, steady all-ones and all-zeros inputs show that the first-stage term is weighted and delayed correctly. Alternating stage-2 patterns drive the word to its +5 and -5 extremes, which exposes sign and width errors in the double differentiator. A pseudo-random mix of both bits catches mistakes in tap ordering. In second order, stage-1 toggling that must not reach the output shows the pass-through is clean. Mode switches, including a request left pending across idle cycles, tell a correct sample-boundary switch, history clear and two-sample warm-up apart from early or missed switches.

// File: rtl/mash_recomb_pkg.sv
// Package: shared mode encoding and decoded analog settings.
// Assumes a two-bit mode code; code 3 is decoded like standard.
package mash_recomb_pkg;

    typedef enum logic [1:0] {
        MODE_LOW   = 2'b00,
        MODE_STD   = 2'b01,
        MODE_HIRES = 2'b10,
        MODE_RSV   = 2'b11
    } mode_e;

    typedef struct packed {
        logic       order4;
        logic [1:0] rate;
        logic       bw_wide;
        logic [1:0] bias;
    } cfg_t;

    // Maps an operating mode to loop order, rate, bandwidth and bias codes.
    function automatic cfg_t decode_mode(input mode_e m);
        cfg_t c;
        case (m)
            MODE_LOW:   c = '{order4: 1'b0, rate: 2'd0, bw_wide: 1'b0, bias: 2'd0};
            MODE_HIRES: c = '{order4: 1'b1, rate: 2'd2, bw_wide: 1'b1, bias: 2'd2};
            default:    c = '{order4: 1'b1, rate: 2'd1, bw_wide: 1'b1, bias: 2'd1};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mash_mode_ctl.sv
// Mode control: holds the active mode and accepts a new request only on a
// sample strobe. A change clears the filter and starts a warm-up of WARM
// processed samples during which output valid stays low.
// Assumes smp_tick is a one-cycle strobe in the block's clock domain.
module mash_mode_ctl
    import mash_recomb_pkg::*;
#(
    parameter int WARM = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       smp_tick,
    output mode_e      mode_q,
    output logic       proc_en,
    output logic       hist_clr,
    output logic       valid_q
);
    localparam int CW = $clog2(WARM + 1);

    logic [CW-1:0] warm_q;
    logic          change;

    // Detect a mode request that differs from the active mode at a strobe.
    always_comb begin
        change   = smp_tick && (mode_e'(mode_sel) != mode_q);
        hist_clr = change;
        proc_en  = smp_tick && !change;
    end

    // Active-mode register, warm-up counter and output-valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_LOW;
            warm_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= proc_en && (warm_q == CW'(WARM));
            if (change) begin
                mode_q <= mode_e'(mode_sel);
                warm_q <= '0;
            end else if (proc_en && (warm_q != CW'(WARM))) begin
                warm_q <= warm_q + CW'(1);
            end
        end
    end

    AST_MODE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_tick |=> $stable(mode_q)); // R6
    AST_CHANGE_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        change |=> !valid_q); // R7
    AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_tick |=> !valid_q); // R8

endmodule

// File: rtl/mash_recomb_filt.sv
// Recombination filter: in fourth order it forms
// a[n-2] + b[n] - 2 b[n-1] + b[n-2], with bits mapped to +1 or -1.
// In second order it passes the stage-2 bit through.
// Assumes hist_clr and proc_en are never high together.
module mash_recomb_filt #(
    parameter int OUT_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    proc_en,
    input  logic                    hist_clr,
    input  logic                    order4,
    input  logic                    s1_bit,
    input  logic                    s2_bit,
    output logic signed [OUT_W-1:0] y_word,
    output logic                    y_bit
);
    localparam int PEAK = 5;

    logic signed [1:0]       a_d1, a_d2, b_d1, b_d2;
    logic signed [1:0]       a_now, b_now;
    logic signed [OUT_W-1:0] sum;

    // Map bits to +1 or -1 and form the merged sum.
    always_comb begin
        a_now = s1_bit ? 2'sb01 : 2'sb11;
        b_now = s2_bit ? 2'sb01 : 2'sb11;
        sum   = OUT_W'(a_d2) + OUT_W'(b_now) - (OUT_W'(b_d1) <<< 1) + OUT_W'(b_d2);
    end

    // Delay line and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n || hist_clr) begin
            a_d1   <= '0;
            a_d2   <= '0;
            b_d1   <= '0;
            b_d2   <= '0;
            y_word <= '0;
            y_bit  <= 1'b0;
        end else if (proc_en) begin
            if (order4) begin
                y_word <= sum;
                y_bit  <= 1'b0;
                a_d1   <= a_now;
                a_d2   <= a_d1;
                b_d1   <= b_now;
                b_d2   <= b_d1;
            end else begin
                y_word <= '0;
                y_bit  <= s2_bit;
            end
        end
    end

    AST_WORD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (y_word <= OUT_W'(PEAK)) && (y_word >= -OUT_W'(PEAK))); // R4
    AST_SECOND_ORDER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_en && !order4) |=> (y_word == '0)); // R5
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_en && !hist_clr) |=> ($stable(y_word) && $stable(y_bit))); // R8

endmodule

// File: rtl/mash_recomb.sv
// Top: recombination back end of a reconfigurable two-stage cascade.
// Ties mode control, settings decode and the recombination filter together.
// Assumes the stage bits are valid whenever smp_tick is high.
module mash_recomb
    import mash_recomb_pkg::*;
#(
    parameter int OUT_W = 4,
    parameter int WARM  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic             smp_tick,
    input  logic             s1_bit,
    input  logic             s2_bit,
    output logic [OUT_W-1:0] y_word,
    output logic             y_bit,
    output logic             y_valid,
    output logic             order4,
    output logic [1:0]       rate_code,
    output logic             bw_wide,
    output logic [1:0]       bias_code,
    output logic             s1_enable,
    output logic             s1_input_sel,
    output logic             tap_merged
);
    mode_e                   mode_q;
    logic                    proc_en, hist_clr;
    cfg_t                    cfg;
    logic signed [OUT_W-1:0] word_s;

    mash_mode_ctl #(.WARM(WARM)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .smp_tick (smp_tick),
        .mode_q   (mode_q),
        .proc_en  (proc_en),
        .hist_clr (hist_clr),
        .valid_q  (y_valid)
    );

    // Decode the active mode into analog-side settings and selectors.
    always_comb begin
        cfg          = decode_mode(mode_q);
        order4       = cfg.order4;
        rate_code    = cfg.rate;
        bw_wide      = cfg.bw_wide;
        bias_code    = cfg.bias;
        s1_enable    = cfg.order4;
        s1_input_sel = cfg.order4;
        tap_merged   = cfg.order4;
    end

    mash_recomb_filt #(.OUT_W(OUT_W)) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .proc_en  (proc_en),
        .hist_clr (hist_clr),
        .order4   (cfg.order4),
        .s1_bit   (s1_bit),
        .s2_bit   (s2_bit),
        .y_word   (word_s),
        .y_bit    (y_bit)
    );

    assign y_word = word_s;

    AST_LOW_MODE_SETTINGS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_LOW) |-> (!s1_enable && rate_code == 2'd0 && bias_code == 2'd0)); // R1
    AST_FOURTH_NO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (y_valid && order4) |-> !y_bit); // R3

endmodule

// File: tb/sim_mash_recomb.sv
module sim_mash_recomb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       smp_tick = 1'b0;
    logic       s1_bit = 1'b0, s2_bit = 1'b0;
    logic [3:0] y_word;
    logic       y_bit, y_valid, order4, bw_wide, s1_enable, s1_input_sel, tap_merged;
    logic [1:0] rate_code, bias_code;

    int total = 0, bad = 0;

    typedef struct {
        logic       v;
        logic [3:0] w;
        logic       b;
        string      tag;
    } exp_t;
    exp_t sb[$];

    // Bench model state.
    int m_mode = 0, m_warm = 0, a1 = 0, a2 = 0, b1 = 0, b2 = 0;
    logic       tick_seen = 1'b0;
    logic [3:0] last_w = '0;

    always #10 clk = ~clk;

    mash_recomb u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .smp_tick(smp_tick),
        .s1_bit(s1_bit), .s2_bit(s2_bit), .y_word(y_word), .y_bit(y_bit),
        .y_valid(y_valid), .order4(order4), .rate_code(rate_code), .bw_wide(bw_wide),
        .bias_code(bias_code), .s1_enable(s1_enable), .s1_input_sel(s1_input_sel),
        .tap_merged(tap_merged)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: applies one strobe and pushes the expected result.
    task automatic sample(input int md, input bit x1, input bit x2, input string tag);
        exp_t e;
        int   pa, pb;
        @(negedge clk);
        mode_sel = md[1:0]; s1_bit = x1; s2_bit = x2; smp_tick = 1'b1;
        pa = x1 ? 1 : -1;
        pb = x2 ? 1 : -1;
        e.tag = tag;
        if (md != m_mode) begin
            m_mode = md; m_warm = 0; a1 = 0; a2 = 0; b1 = 0; b2 = 0;
            e.v = 0; e.w = 4'd0; e.b = 0; e.tag = "R7";
        end else begin
            e.v = (m_warm >= 2);
            if (m_warm < 2) m_warm++;
            if (m_mode != 0) begin
                e.w = 4'(a2 + pb - 2 * b1 + b2);
                e.b = 0;
                a2 = a1; a1 = pa; b2 = b1; b1 = pb;
            end else begin
                e.w = 4'd0;
                e.b = x2;
            end
        end
        sb.push_back(e);
        @(negedge clk);
        smp_tick = 1'b0;
    endtask

    task automatic check_cfg(input int md, input string tag);
        int o, r, w, bi;
        o  = (md == 0) ? 0 : 1;
        r  = (md == 0) ? 0 : (md == 2) ? 2 : 1;
        w  = o;
        bi = r;
        check(order4 == o[0], {tag, " order4"}, order4, o);
        check(rate_code == r[1:0], {tag, " rate_code"}, rate_code, r);
        check(bw_wide == w[0], {tag, " bw_wide"}, bw_wide, w);
        check(bias_code == bi[1:0], {tag, " bias_code"}, bias_code, bi);
        check({s1_enable, s1_input_sel, tap_merged} == {3{o[0]}}, {tag, " selectors"},
              {s1_enable, s1_input_sel, tap_merged}, o * 7);
    endtask

    always @(posedge clk) tick_seen <= smp_tick && rst_n;

    // Monitor: compares results one cycle after each strobe, checks idle cycles.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tick_seen && sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(y_valid == e.v, {e.tag, " valid"}, y_valid, e.v);
                check(y_word == e.w, {e.tag, " word"}, $signed(y_word), $signed(e.w));
                check(y_bit == e.b, {e.tag, " bit"}, y_bit, e.b);
                check(($signed(y_word) <= 5) && ($signed(y_word) >= -5), "R4 range",
                      $signed(y_word), 5);
                last_w <= y_word;
            end else if (!tick_seen) begin
                check(y_valid == 1'b0, "R8 idle valid", y_valid, 0);
                check(y_word == last_w, "R8 hold", $signed(y_word), $signed(last_w));
            end
        end
    end

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog expired actual=1 expected=0");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        // R9 reset state
        check(y_valid == 0, "R9 valid", y_valid, 0);
        check(y_word == 0, "R9 word", y_word, 0);
        check(y_bit == 0, "R9 bit", y_bit, 0);
        check_cfg(0, "R9/R1");
        rst_n = 1'b1;

        // R5 second order: stage-1 toggles, stage-2 passes through
        for (int i = 0; i < 8; i++) sample(0, i[0], i[1] ^ i[2], "R5");
        check_cfg(0, "R1");

        // R6 request pending without strobe: no change
        @(negedge clk); mode_sel = 2'b10;
        repeat (4) @(negedge clk);
        check(order4 == 0, "R6 no switch without tick", order4, 0);
        check(rate_code == 0, "R6 rate held", rate_code, 0);

        // R7 switch to standard, then R3 constant patterns
        sample(1, 1, 1, "R7");
        check_cfg(1, "R2 std");
        for (int i = 0; i < 6; i++) sample(1, 1, 1, "R3 ones");
        for (int i = 0; i < 6; i++) sample(1, 0, 0, "R3 zeros");
        // R4 extremes: alternating stage-2 bit
        for (int i = 0; i < 8; i++) sample(1, i[0] ^ 1'b1, i[0] ^ 1'b1, "R4 alt");
        for (int i = 0; i < 8; i++) sample(1, i[0], i[0], "R4 alt2");

        // High-resolution with pseudo-random bits
        sample(2, 0, 0, "R7");
        check_cfg(2, "R2 hires");
        for (int i = 0; i < 60; i++) sample(2, 1'($urandom), 1'($urandom), "R3 mix");

        // Reserved code decodes like standard
        sample(3, 1, 0, "R7");
        check_cfg(3, "R2 rsv");
        for (int i = 0; i < 10; i++) sample(3, 1'($urandom), 1'($urandom), "R3 rsv");

        // Back to low power: history clears, second order again
        sample(0, 1, 1, "R7");
        check_cfg(0, "R1 back");
        for (int i = 0; i < 6; i++) sample(0, 1'($urandom), i[0], "R5 back");

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule